// File: doc/BRIEF.md
# Condition Flag Generator and Flags Register

This unit sits behind an integer ALU. Each cycle it receives the operand size, an operation class, both ALU operands, the carry-in and the ALU result. From these it derives six arithmetic condition flags: carry, parity, auxiliary carry, zero, sign and overflow. When an update strobe is high, it folds those flags into a 32-bit packed flags word on the next clock edge.

The flags word also holds system and control bits, such as trap, interrupt enable, direction, privilege level, nested task, resume, virtual mode and alignment check. The arithmetic path never writes these bits. They change only through a separate whole-word load port. That port is also how a saved flags word is restored. Reserved positions are forced to constant values whatever is written.

The result bus is trusted to hold the true ALU result for the add and subtract classes. Overflow and auxiliary carry are read from the result together with the operand bits. Carry and borrow are recomputed from the operands.

Top module: `flag_unit`

## Requirements
- R1: After an asynchronous reset (rst_ni low), flags_o reads 32'h0000_0002 and every individual flag output reads 0.
- R2: Bit 1 of flags_o always reads 1. Bits 3, 5, 15 and 31:22 always read 0, including after a load that writes ones there.
- R3: Condition flags sit at fixed positions in the packed word: carry bit 0, parity bit 2, auxiliary bit 4, zero bit 6, sign bit 7, overflow bit 11. The flags take their new value on the rising clock edge where upd_en_i is high. When upd_en_i and load_i are both low, flags_o holds. Each individual output equals its bit of flags_o.
- R4: size_i selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 or 3 is 32 bits. Zero is set when the result bits below that width are all 0. Sign copies the result bit at the top of that width. Result bits above the width are ignored.
- R5: Parity is set when res_i[7:0] holds an even number of ones, at every operand size, for op_i codes 0 to 4.
- R6: op_i encodes the class: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 logical, 5 to 7 pass-through. Carry is the unsigned carry out of the top bit for codes 0 and 1. It is the unsigned borrow for codes 2 and 3. carry_i is added or subtracted only for codes 1 and 3.
- R7: Overflow is set when the signed result does not fit the selected width for codes 0 to 3. For example, at 16 bits, 7FFFh plus 0001h sets it.
- R8: Auxiliary carry is the carry or borrow out of bit 3 for codes 0 to 3.
- R9: For code 4, carry, overflow and auxiliary carry are cleared. Zero, sign and parity follow the result.
- R10: For codes 5 to 7, an update leaves the whole flags word unchanged.
- R11: When load_i is high, the next edge writes load_val_i masked by 32'h003F_7FD5 and then ORed with 32'h0000_0002. load_i takes priority over upd_en_i.
- R12: The arithmetic path never changes bits 8 to 10, 12 to 14 or 16 to 21. Only a load writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_en_i | input | 1 | Fold computed condition flags into the register |
| size_i | input | 2 | Operand width select |
| op_i | input | 3 | Operation class |
| opa_i | input | 32 | First ALU operand |
| opb_i | input | 32 | Second ALU operand |
| carry_i | input | 1 | Carry or borrow in for the with-carry classes |
| res_i | input | 32 | ALU result |
| load_i | input | 1 | Whole-word load strobe |
| load_val_i | input | 32 | Word written on a load |
| flags_o | output | 32 | Packed flags word |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |

## Verification
The hardest situation to reach is one where the system bits hold a non-trivial pattern while the arithmetic path keeps rewriting the condition bits around them. Random stimulus rarely asserts load with an interesting value at the right moment. The bench therefore loads an all-ones word first, and later a mixed pattern. It then runs long random arithmetic sequences across all sizes and classes. It also places result bits above the selected width that disagree with the low part, so that masking errors in zero and sign show up.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;
  localparam int unsigned FLAGS_W = 32;

  localparam int unsigned CF_POS = 0;
  localparam int unsigned PF_POS = 2;
  localparam int unsigned AF_POS = 4;
  localparam int unsigned ZF_POS = 6;
  localparam int unsigned SF_POS = 7;
  localparam int unsigned OF_POS = 11;

  localparam logic [FLAGS_W-1:0] LOAD_MASK  = 32'h003F_7FD5;
  localparam logic [FLAGS_W-1:0] FIXED_ONES = 32'h0000_0002;
  localparam logic [FLAGS_W-1:0] RESET_WORD = FIXED_ONES;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBB   = 3'd3,
    OP_LOGIC = 3'd4,
    OP_PASS  = 3'd5
  } op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } cond_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] res_i,
  output cond_t             cond_o,
  output logic              touch_o
);
  localparam int unsigned NUM_SIZES = $clog2(DATA_W / 8) + 1;

  logic is_sub, is_arith, is_logic, cin;
  logic [NUM_SIZES-1:0] lane_cf, lane_of, lane_zf, lane_sf;
  logic [1:0] sel;

  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SBB);
  assign is_arith = (op_i <= OP_SBB);
  assign is_logic = (op_i == OP_LOGIC);
  assign cin      = carry_i & ((op_i == OP_ADC) || (op_i == OP_SBB));

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_lane
    localparam int unsigned W = 8 << s;
    logic a_m, b_m, r_m, co, bo;
    assign a_m = opa_i[W-1];
    assign b_m = opb_i[W-1];
    assign r_m = res_i[W-1];
    // carry/borrow recomputed from operands, only the top bit kept
    assign co = 1'(({1'b0, opa_i[W-1:0]} + {1'b0, opb_i[W-1:0]}
                     + {{W{1'b0}}, cin}) >> W);
    assign bo = 1'(({1'b0, opa_i[W-1:0]} - {1'b0, opb_i[W-1:0]}
                     - {{W{1'b0}}, cin}) >> W);
    assign lane_cf[s] = is_sub ? bo : co;
    assign lane_of[s] = is_sub ? ((a_m ^ b_m) & (r_m ^ a_m))
                               : (~(a_m ^ b_m) & (r_m ^ a_m));
    assign lane_zf[s] = ~|res_i[W-1:0];
    assign lane_sf[s] = r_m;
  end

  assign sel = (int'(size_i) >= NUM_SIZES) ? 2'(NUM_SIZES - 1) : size_i;

  always_comb begin
    cond_o.pf_f = ~^res_i[7:0];
    cond_o.zf_f = lane_zf[sel];
    cond_o.sf_f = lane_sf[sel];
    cond_o.cf_f = is_arith & lane_cf[sel];
    cond_o.of_f = is_arith & lane_of[sel];
    cond_o.af_f = is_arith & (opa_i[4] ^ opb_i[4] ^ res_i[4]);
  end

  assign touch_o = is_arith | is_logic;
endmodule

// File: rtl/flag_pack.sv
module flag_pack
  import flag_unit_pkg::*;
(
  input  logic [FLAGS_W-1:0] cur_i,
  input  cond_t              cond_i,
  output logic [FLAGS_W-1:0] merged_o
);
  always_comb begin
    merged_o         = cur_i;
    merged_o[CF_POS] = cond_i.cf_f;
    merged_o[PF_POS] = cond_i.pf_f;
    merged_o[AF_POS] = cond_i.af_f;
    merged_o[ZF_POS] = cond_i.zf_f;
    merged_o[SF_POS] = cond_i.sf_f;
    merged_o[OF_POS] = cond_i.of_f;
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_unit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic               load_i,
  input  logic [FLAGS_W-1:0] load_val_i,
  input  logic [FLAGS_W-1:0] merged_i,
  output logic [FLAGS_W-1:0] q_o
);
  logic [FLAGS_W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (load_i)     q_d = (load_val_i & LOAD_MASK) | FIXED_ONES;
    else if (upd_i) q_d = merged_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RESET_WORD;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [1:0]        size_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              load_i,
  input  logic [31:0]       load_val_i,
  output logic [31:0]       flags_o,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              of_o
);
  cond_t              cond;
  logic               touch;
  logic [FLAGS_W-1:0] cur, merged;

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op_i   (op_i),
    .size_i (size_i),
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .carry_i(carry_i),
    .res_i  (res_i),
    .cond_o (cond),
    .touch_o(touch)
  );

  flag_pack u_pack (
    .cur_i   (cur),
    .cond_i  (cond),
    .merged_o(merged)
  );

  flag_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_en_i & touch),
    .load_i    (load_i),
    .load_val_i(load_val_i),
    .merged_i  (merged),
    .q_o       (cur)
  );

  assign flags_o = cur;
  assign cf_o    = cur[CF_POS];
  assign pf_o    = cur[PF_POS];
  assign af_o    = cur[AF_POS];
  assign zf_o    = cur[ZF_POS];
  assign sf_o    = cur[SF_POS];
  assign of_o    = cur[OF_POS];
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_unit_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_en_i,
  input logic [1:0]        size_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] res_i,
  input logic              load_i,
  input logic [31:0]       load_val_i,
  input logic [31:0]       flags_o,
  input logic              cf_o,
  input logic              pf_o,
  input logic              af_o,
  input logic              sf_o,
  input logic              of_o
);
  p_fixed_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] && !flags_o[3] && !flags_o[5] && !flags_o[15] && (flags_o[31:22] == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i && !load_i) |=> $stable(flags_o));

  p_sign_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !load_i && op_i <= 3'd4 && size_i[1]) |=> (sf_o == $past(res_i[31])));

  p_parity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !load_i && op_i <= 3'd4) |=> (pf_o == ~^$past(res_i[7:0])));

  p_logic_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !load_i && op_i == 3'd4) |=> (!cf_o && !of_o && !af_o));

  p_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !load_i && op_i >= 3'd5) |=> $stable(flags_o));

  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flags_o == (($past(load_val_i) & LOAD_MASK) | FIXED_ONES)));

  p_sys_bits_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(flags_o[10:8]) && $stable(flags_o[14:12]) && $stable(flags_o[21:16])));
endmodule

bind flag_unit flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .upd_en_i  (upd_en_i),
  .size_i    (size_i),
  .op_i      (op_i),
  .res_i     (res_i),
  .load_i    (load_i),
  .load_val_i(load_val_i),
  .flags_o   (flags_o),
  .cf_o      (cf_o),
  .pf_o      (pf_o),
  .af_o      (af_o),
  .sf_o      (sf_o),
  .of_o      (of_o)
);

// File: tb/flag_unit_tb.sv
module flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, ld = 1'b0, cin = 1'b0;
  logic [1:0]  sz = '0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0, r = '0, lv = '0;
  logic [31:0] flags;
  logic        cf, pf, af, zf, sf, ovf;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] exp_q = 32'h2;

  always #4 clk = ~clk;

  flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_en_i(upd), .size_i(sz), .op_i(op),
    .opa_i(a), .opb_i(b), .carry_i(cin), .res_i(r), .load_i(ld),
    .load_val_i(lv), .flags_o(flags), .cf_o(cf), .pf_o(pf), .af_o(af),
    .zf_o(zf), .sf_o(sf), .of_o(ovf)
  );

  function automatic logic [31:0] ref_next(logic [31:0] q);
    int w;
    longint msk, ua, ub, ur, sa, sb, sres, cc, smax, smin;
    logic [31:0] n;
    bit fc, fa, fo;
    if (ld) return (lv & 32'h003F_7FD5) | 32'h2;
    if (!upd || op > 3'd4) return q;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    msk  = (64'sd1 <<< w) - 1;
    ua   = longint'(a) & msk;
    ub   = longint'(b) & msk;
    ur   = longint'(r) & msk;
    cc   = ((op == 3'd1 || op == 3'd3) && cin) ? 1 : 0;
    sa   = ((ua >>> (w - 1)) & 1) != 0 ? ua - (msk + 1) : ua;
    sb   = ((ub >>> (w - 1)) & 1) != 0 ? ub - (msk + 1) : ub;
    smax = (64'sd1 <<< (w - 1)) - 1;
    smin = -(64'sd1 <<< (w - 1));
    fc = 0; fa = 0; fo = 0;
    if (op <= 3'd1) begin
      fc   = (ua + ub + cc) > msk;
      fa   = ((ua & 15) + (ub & 15) + cc) > 15;
      sres = sa + sb + cc;
      fo   = (sres > smax) || (sres < smin);
    end else if (op <= 3'd3) begin
      fc   = ua < (ub + cc);
      fa   = (ua & 15) < ((ub & 15) + cc);
      sres = sa - sb - cc;
      fo   = (sres > smax) || (sres < smin);
    end
    n     = q;
    n[0]  = fc;
    n[2]  = ~^r[7:0];
    n[4]  = fa;
    n[6]  = (ur == 0);
    n[7]  = ((ur >>> (w - 1)) & 1) != 0;
    n[11] = fo;
    return n;
  endfunction

  // correct ALU result in the low width, noise above it
  function automatic logic [31:0] make_res(logic [31:0] noise);
    int w;
    longint msk, ua, ub, cc, t;
    w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    msk = (64'sd1 <<< w) - 1;
    ua  = longint'(a) & msk;
    ub  = longint'(b) & msk;
    cc  = ((op == 3'd1 || op == 3'd3) && cin) ? 1 : 0;
    if (op <= 3'd1)      t = (ua + ub + cc) & msk;
    else if (op <= 3'd3) t = (ua - ub - cc) & msk;
    else                 return noise;
    return (noise & ~32'(msk)) | 32'(t);
  endfunction

  task automatic compare(string req);
    logic [37:0] act, expv;
    act  = {flags, ovf, sf, zf, af, pf, cf};
    expv = {exp_q, exp_q[11], exp_q[7], exp_q[6], exp_q[4], exp_q[2], exp_q[0]};
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (flags %h vs %h)", req, act, expv, flags, exp_q);
    end
  endtask

  task automatic compare_lit(string req, logic [31:0] lit);
    vectors++;
    if (flags !== lit) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, flags, lit);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    exp_q = ref_next(exp_q);
    @(negedge clk);
    compare(req);
  endtask

  task automatic arith(input logic [2:0] o, input logic [1:0] s, input logic [31:0] x,
                       input logic [31:0] y, input logic c, input logic [31:0] noise, string req);
    op = o; sz = s; a = x; b = y; cin = c; upd = 1'b1; ld = 1'b0;
    r = make_res(noise);
    step(req);
  endtask

  task automatic do_load(input logic [31:0] v, input logic with_upd, string req);
    ld = 1'b1; lv = v; upd = with_upd; op = 3'd0; sz = 2'd2;
    a = 32'h1; b = 32'h1; r = 32'h2;
    step(req);
    ld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_lit("R1 during reset", 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // 16-bit 7FFF + 1: overflow, sign, aux, parity of 00h
    arith(3'd0, 2'd1, 32'h7FFF, 32'h0001, 1'b0, 32'h0, "R7 16-bit overflow");
    compare_lit("R3 R7 packed positions", 32'h0000_0896);
    arith(3'd0, 2'd0, 32'hFF, 32'h01, 1'b0, 32'hABCD_1200, "R4 R6 8-bit carry zero");
    arith(3'd1, 2'd0, 32'hFE, 32'h01, 1'b1, 32'h0, "R6 adc carry-in");
    arith(3'd0, 2'd0, 32'hFE, 32'h01, 1'b1, 32'h0, "R6 add ignores carry-in");
    arith(3'd2, 2'd2, 32'h0, 32'h1, 1'b0, 32'h0, "R6 R8 borrow 32-bit");
    arith(3'd3, 2'd1, 32'h5, 32'h5, 1'b1, 32'h0, "R6 sbb borrow-in");
    arith(3'd2, 2'd1, 32'h8000, 32'h0001, 1'b0, 32'h0, "R7 sub overflow");
    arith(3'd0, 2'd0, 32'h0F, 32'h01, 1'b0, 32'h0, "R8 nibble carry");
    arith(3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0, "R4 size 3 as 32");
    arith(3'd4, 2'd0, 32'h0, 32'h0, 1'b0, 32'hFFFF_FF03, "R5 R9 logic parity");
    arith(3'd4, 2'd1, 32'h0, 32'h0, 1'b0, 32'h0001_0000, "R4 upper bits ignored");
    do_load(32'hFFFF_FFFF, 1'b0, "R2 R11 load all ones");
    compare_lit("R2 R11 masked load", 32'h003F_7FD7);
    arith(3'd2, 2'd2, 32'h1, 32'h1, 1'b0, 32'h0, "R12 sys bits kept");
    arith(3'd5, 2'd0, 32'h7F, 32'h1, 1'b0, 32'h0, "R10 pass-through");
    arith(3'd7, 2'd0, 32'h7F, 32'h1, 1'b0, 32'h0, "R10 code 7");
    op = 3'd0; upd = 1'b0; a = 32'hFF; b = 32'h1; r = 32'h0;
    step("R3 hold without update");
    do_load(32'h0015_A4C1, 1'b1, "R11 load priority");

    for (int i = 0; i < 3000; i++) begin
      string tag;
      op  = 3'($urandom_range(0, 7));
      sz  = 2'($urandom_range(0, 3));
      a   = $urandom; b = $urandom;
      if (($urandom & 3) == 0) b = a;
      cin = 1'($urandom);
      upd = ($urandom % 10) < 8;
      ld  = ($urandom % 20) == 0;
      lv  = $urandom;
      r   = make_res($urandom);
      if (ld)             tag = "R11 random load";
      else if (op <= 3'd3) tag = "R4 R5 R6 R7 R8 R12 random arith";
      else if (op == 3'd4) tag = "R9 random logic";
      else                tag = "R10 random pass";
      step(tag);
    end
    ld = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule